// File: doc/BRIEF.md
# System Address Range Decoder

This block maps a physical address to the memory controller and the channel that own it. A request arrives on a valid/ready port. The block first checks the address against two bounds: the top of low memory and the top of high memory. It then walks a programmable table of range rules, one entry per clock, until it finds the entry that holds the address. Each entry is a 32-bit rule word paired with a 32-bit interleave-list word. Entries are stored in a synchronous memory that has a simple write port.

The rule that matches chooses a group of address bits. Those bits select a 4-bit target from the interleave list. The target is either a remote node, which the block reports, or a local target. For a local target, a logical channel is formed, either directly from the target or through a modulo-3 or modulo-2 fold of a shifted address. A route word then turns that logical channel into a controller number and a channel number. Every response carries a status code, and it is held until the consumer accepts it.

Top module: `sys_range_decoder`

## Requirements
- R1: An address at or above `cfg_tohm` is rejected with status 1 (out of range). So is an address at or above `cfg_tolm` whose bits above bit 31 are all zero. In both cases the table is not scanned.
- R2: Table entries are contiguous. Entry 0 starts at 0. Each later entry starts one above the limit of the entry before it, whether or not that earlier entry is enabled. The limit is rule bits 26:7 shifted left by 26 with the low 26 bits set to one. The first enabled entry (rule bit 0) whose range holds the address wins.
- R3: When no enabled entry holds the address, the status is 2 (no match).
- R4: The interleave mode is rule bits 2:1. It selects a 3-bit index from the address: bits 8:6 for mode 0, 10:8 for mode 1, 14:12 for mode 2 and 32:30 for mode 3. The target is the interleave-list nibble at bit position 4 times the index.
- R5: A target with bit 3 clear is remote. The status is 3 and `rsp_node` carries target bits 2:0. `rsp_node` is 0 for every other status.
- R6: With rule bit 27 clear, the logical channel is target bits 2:0. The controller is route bits [3l+2:3l] and the channel is route bits [2l+19:2l+18], where l is the logical channel. Route bits above 31 read as zero. The status is 0, and controller and channel read 0 for every status other than 0.
- R7: With rule bit 27 set, the address is shifted right by 6, 8 or 12 for rule bits 31:30 equal to 0, 1 or 2. Rule bits 6:5 then select a 2-bit fold value. Code 0 gives the shifted value modulo 3. Code 1 gives {0,b}, code 2 gives {b,~b} and code 3 gives {b,0}, where b is bit 0 of the shifted value. The logical channel is {fold, target bit 0}.
- R8: With rule bit 27 set and rule bits 31:30 equal to 3, a local target yields status 4 (illegal mode).
- R9: `req_ready` is high only while the block is idle, so a new request is not accepted while one is in flight. A response keeps `rsp_valid` high and its fields unchanged until `rsp_ready` is seen.
- R10: Counted in clock edges after the edge that accepts a request, `rsp_valid` rises after 1 edge for an out-of-range address, after k+3 edges for a hit on entry k, and after ENTRIES+1 edges for a miss.
- R11: After reset `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table entry write enable |
| tbl_idx | input | IDX_W | Table entry index to write |
| tbl_rule | input | 32 | Rule word to write |
| tbl_ilv | input | 32 | Interleave-list word to write |
| cfg_tolm | input | ADDR_W | Top of low memory bound |
| cfg_tohm | input | ADDR_W | Top of high memory bound |
| cfg_route | input | 32 | Route word, logical channel to controller/channel |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Physical address to decode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_status | output | 3 | 0 ok, 1 out of range, 2 no match, 3 remote, 4 illegal mode |
| rsp_mc | output | 3 | Controller number |
| rsp_chan | output | 2 | Channel number |
| rsp_node | output | 3 | Remote node id |

## Verification
Several properties are checked on every cycle:
- A request is refused while another is in flight.
- A pending response is held steady.
- The scan pointer stays inside the table.
- An OK result always comes from an enabled rule.
- Any response other than out-of-range carries an address below the high bound.
- A folded logical channel never exceeds 5.

The bench scenarios cover the rest. These are the actual bit selections per interleave mode, the fold arithmetic, the route-word indirection, the chained lower bound over a disabled entry, the boundary addresses at both memory tops, and the scan latency for each entry position.

// File: rtl/srd_pkg.sv
package srd_pkg;

  localparam int RULE_W      = 32;
  localparam int RB_EN       = 0;
  localparam int RB_MODE_LO  = 1;
  localparam int RB_FOLD_LO  = 5;
  localparam int RB_LIM_LO   = 7;
  localparam int LIM_FIELD_W = 20;
  localparam int RB_MOD3     = 27;
  localparam int RB_SHIFT_LO = 30;
  localparam int LIM_LSB     = 26;
  localparam int LIMIT_W     = LIM_FIELD_W + LIM_LSB;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_RANGE   = 3'd1,
    ST_MISS    = 3'd2,
    ST_REMOTE  = 3'd3,
    ST_BADMODE = 3'd4
  } srd_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_SCAN,
    S_RESOLVE,
    S_RESP
  } srd_state_e;

  // Inclusive upper address of a rule: coarse field with all-ones fill below.
  function automatic logic [LIMIT_W-1:0] rule_limit(input logic [RULE_W-1:0] r);
    return {r[RB_LIM_LO +: LIM_FIELD_W], {LIM_LSB{1'b1}}};
  endfunction

endpackage

// File: rtl/srd_rule_mem.sv
module srd_rule_mem #(
  parameter int DEPTH  = 24,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < DEPTH)) begin
      mem[wr_idx] <= wr_data;
    end
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/srd_bounds.sv
module srd_bounds #(
  parameter int ADDR_W = 46
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] tohm,
  output logic              reject
);

  localparam int GIB4_BIT = 32;

  logic below_4g;

  assign below_4g = (addr >> GIB4_BIT) == '0;
  // Above high top, or inside the hole between low top and 4 GiB.
  assign reject = (addr >= tohm) || ((addr >= tolm) && below_4g);

endmodule

// File: rtl/srd_target.sv
module srd_target
  import srd_pkg::*;
#(
  parameter int ADDR_W = 46
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       rule,
  input  logic [31:0]       ilv,
  input  logic [31:0]       route,
  output srd_status_e       status,
  output logic [2:0]        node,
  output logic [2:0]        mc,
  output logic [1:0]        chan,
  output logic [2:0]        lch
);

  localparam int NLCH  = 8;
  localparam int RT_W  = 36;
  localparam int CH_LO = 18;

  logic [2:0]        idx;
  logic [3:0]        tgt;
  logic [3:0]        shamt;
  logic              bad_shift;
  logic [ADDR_W-1:0] shifted;
  logic [1:0]        rem3;
  logic [1:0]        fold;
  logic              use_fold;
  logic [RT_W-1:0]   route_x;
  logic [2:0]        mc_tab [NLCH];
  logic [1:0]        ch_tab [NLCH];
  logic              unused_rule_bits;

  assign unused_rule_bits = ^{rule[4:3], rule[29:28]};

  // Interleave index from the address field picked by the mode.
  always_comb begin
    unique case (rule[RB_MODE_LO +: 2])
      2'd0:    idx = addr[8:6];
      2'd1:    idx = addr[10:8];
      2'd2:    idx = addr[14:12];
      default: idx = addr[32:30];
    endcase
  end

  assign tgt = ilv[{idx, 2'b00} +: 4];

  always_comb begin
    bad_shift = 1'b0;
    unique case (rule[RB_SHIFT_LO +: 2])
      2'd0:    shamt = 4'd6;
      2'd1:    shamt = 4'd8;
      2'd2:    shamt = 4'd12;
      default: begin shamt = 4'd6; bad_shift = 1'b1; end
    endcase
  end

  assign shifted = addr >> shamt;
  assign rem3    = 2'(shifted % ADDR_W'(3));

  always_comb begin
    unique case (rule[RB_FOLD_LO +: 2])
      2'd0:    fold = rem3;
      2'd1:    fold = {1'b0, shifted[0]};
      2'd2:    fold = {shifted[0], ~shifted[0]};
      default: fold = {shifted[0], 1'b0};
    endcase
  end

  assign use_fold = rule[RB_MOD3];
  assign lch      = use_fold ? {fold, tgt[0]} : tgt[2:0];

  // Route word fields per logical channel; bits past 31 read zero.
  assign route_x = {{(RT_W-32){1'b0}}, route};
  for (genvar g = 0; g < NLCH; g++) begin : g_route
    assign mc_tab[g] = route_x[3*g +: 3];
    assign ch_tab[g] = route_x[2*g + CH_LO +: 2];
  end

  always_comb begin
    status = ST_OK;
    node   = '0;
    mc     = '0;
    chan   = '0;
    if (!tgt[3]) begin
      status = ST_REMOTE;
      node   = tgt[2:0];
    end else if (use_fold && bad_shift) begin
      status = ST_BADMODE;
    end else begin
      mc   = mc_tab[lch];
      chan = ch_tab[lch];
    end
  end

endmodule

// File: rtl/sys_range_decoder.sv
module sys_range_decoder
  import srd_pkg::*;
#(
  parameter  int ENTRIES = 24,
  parameter  int ADDR_W  = 46,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [31:0]       tbl_rule,
  input  logic [31:0]       tbl_ilv,
  input  logic [ADDR_W-1:0] cfg_tolm,
  input  logic [ADDR_W-1:0] cfg_tohm,
  input  logic [31:0]       cfg_route,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_status,
  output logic [2:0]        rsp_mc,
  output logic [1:0]        rsp_chan,
  output logic [2:0]        rsp_node
);

  localparam int              LO_W   = ADDR_W + 1;
  localparam int              ENT_W  = 64;
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);

  srd_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  ptr;
  logic [IDX_W-1:0]  rd_idx;
  logic [LO_W-1:0]   lo_q;
  logic [LO_W-1:0]   lim_ext;
  logic [ENT_W-1:0]  rd_q;
  logic [31:0]       hit_rule;
  logic [31:0]       hit_ilv;
  logic              reject;
  logic              hit;
  srd_status_e       st_q;
  logic [2:0]        mc_q;
  logic [1:0]        ch_q;
  logic [2:0]        node_q;
  srd_status_e       t_status;
  logic [2:0]        t_node;
  logic [2:0]        t_mc;
  logic [1:0]        t_chan;
  logic [2:0]        t_lch;

  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_RESP);
  assign rsp_status = st_q;
  assign rsp_mc     = mc_q;
  assign rsp_chan   = ch_q;
  assign rsp_node   = node_q;

  // Prefetch: while entry ptr is compared, entry ptr+1 is read.
  always_comb begin
    rd_idx = '0;
    if (state == S_SCAN) begin
      rd_idx = (ptr == LAST) ? LAST : ptr + 1'b1;
    end
  end

  srd_rule_mem #(
    .DEPTH (ENTRIES),
    .IDX_W (IDX_W),
    .DATA_W(ENT_W)
  ) u_mem (
    .clk    (clk),
    .wr_en  (tbl_we),
    .wr_idx (tbl_idx),
    .wr_data({tbl_ilv, tbl_rule}),
    .rd_idx (rd_idx),
    .rd_data(rd_q)
  );

  srd_bounds #(.ADDR_W(ADDR_W)) u_bounds (
    .addr  (addr_q),
    .tolm  (cfg_tolm),
    .tohm  (cfg_tohm),
    .reject(reject)
  );

  assign lim_ext = LO_W'(rule_limit(rd_q[31:0]));
  assign hit     = rd_q[RB_EN] && ({1'b0, addr_q} >= lo_q) && ({1'b0, addr_q} <= lim_ext);

  srd_target #(.ADDR_W(ADDR_W)) u_target (
    .addr  (addr_q),
    .rule  (hit_rule),
    .ilv   (hit_ilv),
    .route (cfg_route),
    .status(t_status),
    .node  (t_node),
    .mc    (t_mc),
    .chan  (t_chan),
    .lch   (t_lch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      ptr      <= '0;
      lo_q     <= '0;
      hit_rule <= '0;
      hit_ilv  <= '0;
      st_q     <= ST_OK;
      mc_q     <= '0;
      ch_q     <= '0;
      node_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            state  <= S_CHECK;
          end
        end
        S_CHECK: begin
          ptr  <= '0;
          lo_q <= '0;
          if (reject) begin
            st_q   <= ST_RANGE;
            mc_q   <= '0;
            ch_q   <= '0;
            node_q <= '0;
            state  <= S_RESP;
          end else begin
            state <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (hit) begin
            hit_rule <= rd_q[31:0];
            hit_ilv  <= rd_q[63:32];
            state    <= S_RESOLVE;
          end else if (ptr == LAST) begin
            st_q   <= ST_MISS;
            mc_q   <= '0;
            ch_q   <= '0;
            node_q <= '0;
            state  <= S_RESP;
          end else begin
            ptr  <= ptr + 1'b1;
            lo_q <= lim_ext + 1'b1;
          end
        end
        S_RESOLVE: begin
          st_q   <= t_status;
          mc_q   <= t_mc;
          ch_q   <= t_chan;
          node_q <= t_node;
          state  <= S_RESP;
        end
        S_RESP: begin
          if (rsp_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_mc)
                                   && $stable(rsp_chan) && $stable(rsp_node)));

  // R1
  range_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_RANGE) |-> (addr_q < cfg_tohm));

  // R2
  hit_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_OK) |-> hit_rule[RB_EN]);

  // R3
  scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_SCAN) |-> (ptr <= LAST));

  // R5
  node_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_REMOTE) |-> (rsp_node == 3'd0));

  // R7
  fold_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RESOLVE && hit_rule[RB_MOD3] && t_status == ST_OK) |-> (t_lch < 3'd6));

endmodule

// File: tb/sys_range_decoder_test.sv
`timescale 1ns/1ps
module sys_range_decoder_test;

  localparam int ENTRIES = 24;
  localparam int ADDR_W  = 46;
  localparam int IDX_W   = 5;
  localparam int NV      = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tbl_we = 1'b0;
  logic [IDX_W-1:0]  tbl_idx = '0;
  logic [31:0]       tbl_rule = '0;
  logic [31:0]       tbl_ilv = '0;
  logic [ADDR_W-1:0] cfg_tolm = 46'h8000_0000;
  logic [ADDR_W-1:0] cfg_tohm = 46'h100_0000_0000;
  logic [31:0]       cfg_route = 32'hD392_C688;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [2:0]        rsp_status;
  logic [2:0]        rsp_mc;
  logic [1:0]        rsp_chan;
  logic [2:0]        rsp_node;

  int nchk  = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  sys_range_decoder #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_rule(tbl_rule),
    .tbl_ilv(tbl_ilv), .cfg_tolm(cfg_tolm), .cfg_tohm(cfg_tohm), .cfg_route(cfg_route),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_mc(rsp_mc), .rsp_chan(rsp_chan), .rsp_node(rsp_node)
  );

  // Route word: logical channel -> (controller, channel):
  // 0:(0,0) 1:(1,1) 2:(2,2) 3:(3,3) 4:(4,0) 5:(5,1) 6:(4,3) 7:(4,0)
  localparam logic [ADDR_W-1:0] VA [NV] = '{
    46'h140,            // R4 mode 0, index 5
    46'h40,             // R6 logical channel 6
    46'hFFF_FFFF,       // R2 top of entry 0
    46'h2000_0300,      // R4 mode 1
    46'h1000_0000,      // R2 disabled entry 1 skipped, entry 23 hit
    46'h4000_51C0,      // R7 modulo 3
    46'h7FFF_FFFF,      // R1 just below low top
    46'h1_0000_0100,    // R7 modulo 2
    46'h1_0000_0000,    // R4 mode 3 at 4 GiB
    46'h1_4000_1040,    // R7 fold code 2
    46'h1_8000_0080,    // R7 fold code 3
    46'h1_C000_0000,    // R8 illegal shift
    46'h2_0000_0180,    // R5 remote
    46'h9000_0000,      // R1 hole
    46'h100_0000_0000,  // R1 at high top
    46'hFF_FFFF_FFFF    // R10 last entry
  };
  localparam logic [2:0] VS [NV] = '{0,0,0,0,0,0,0,0,0,0,0,4,3,1,1,0};
  localparam logic [2:0] VM [NV] = '{2,4,0,4,4,2,2,3,1,4,1,0,0,0,0,0};
  localparam logic [1:0] VC [NV] = '{2,3,0,0,0,2,2,3,1,0,1,0,0,0,0,0};
  localparam logic [2:0] VN [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,6,0,0,0};
  localparam int         VL [NV] = '{3,3,3,5,26,6,6,7,7,8,9,10,11,1,1,26};

  function automatic string vtag(input int i);
    case (i)
      0:  return "R4 mode0 index";
      1:  return "R6 direct lch";
      2:  return "R2 entry0 edge";
      3:  return "R4 mode1 index";
      4:  return "R2 chained bound";
      5:  return "R7 mod3 fold";
      6:  return "R1 below tolm";
      7:  return "R7 mod2 fold";
      8:  return "R4 mode3 index";
      9:  return "R7 fold code2";
      10: return "R7 fold code3";
      11: return "R8 illegal shift";
      12: return "R5 remote target";
      13: return "R1 hole";
      14: return "R1 at tohm";
      default: return "R10 last entry";
    endcase
  endfunction

  function automatic logic [31:0] mk_rule(input int lim, input int mode, input int en,
                                          input int m3, input int sh, input int fold);
    return (32'(sh) << 30) | (32'(m3) << 27) | (32'(lim) << 7) | (32'(fold) << 5)
         | (32'(mode) << 1) | 32'(en);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prog(input int idx, input logic [31:0] rule, input logic [31:0] ilv);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IDX_W'(idx); tbl_rule = rule; tbl_ilv = ilv;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  // Issue one request and count edges until rsp_valid.
  task automatic issue(input logic [ADDR_W-1:0] a, output int lat);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!rsp_valid && lat < 200);
  endtask

  task automatic consume();
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lat;
    logic [2:0] s0, m0, n0;
    logic [1:0] c0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    check("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R11 req_ready after reset", 64'(req_ready), 64'd1);

    prog(0, mk_rule(3, 0, 1, 0, 0, 0), 32'h89AB_CDEF);
    prog(1, mk_rule(7, 0, 0, 0, 0, 0), 32'h89AB_CDEF);
    prog(2, mk_rule(15, 1, 1, 0, 0, 0), 32'h89AB_CDEF);
    prog(3, mk_rule(31, 2, 1, 1, 0, 0), 32'h89AB_CDEF);
    prog(4, mk_rule('h4F, 3, 1, 1, 1, 1), 32'h89AB_CDEF);
    prog(5, mk_rule('h5F, 0, 1, 1, 2, 2), 32'h89AB_CDEF);
    prog(6, mk_rule('h6F, 0, 1, 1, 0, 3), 32'h89AB_CDEF);
    prog(7, mk_rule('h7F, 0, 1, 1, 3, 0), 32'h89AB_CDEF);
    prog(8, mk_rule('h8F, 0, 1, 0, 0, 0), 32'h7654_3210);
    for (int e = 9; e < 23; e++) prog(e, 32'h0, 32'h0);
    prog(23, mk_rule('hFFFFF, 0, 1, 0, 0, 0), 32'h89AB_CDEF);

    for (int i = 0; i < NV; i++) begin
      issue(VA[i], lat);
      check({vtag(i), " status"}, 64'(rsp_status), 64'(VS[i]));
      check({vtag(i), " mc"},     64'(rsp_mc),     64'(VM[i]));
      check({vtag(i), " chan"},   64'(rsp_chan),   64'(VC[i]));
      check({vtag(i), " node"},   64'(rsp_node),   64'(VN[i]));
      check({vtag(i), " R10 latency"}, 64'(lat),   64'(VL[i]));
      if (i == 3) begin
        s0 = rsp_status; m0 = rsp_mc; c0 = rsp_chan; n0 = rsp_node;
        repeat (2) @(posedge clk);
        #1;
        check("R9 held valid", 64'(rsp_valid), 64'd1);
        check("R9 held fields", 64'({rsp_status, rsp_mc, rsp_chan, rsp_node}),
              64'({s0, m0, c0, n0}));
        check("R9 busy not ready", 64'(req_ready), 64'd0);
      end
      consume();
      check("R9 released", 64'({rsp_valid, req_ready}), 64'b01);
    end

    // R3: disable the catch-all entry, the same address now misses.
    prog(23, mk_rule('hFFFFF, 0, 0, 0, 0, 0), 32'h89AB_CDEF);
    issue(46'h1000_0000, lat);
    check("R3 miss status", 64'(rsp_status), 64'd2);
    check("R3 miss mc/chan", 64'({rsp_mc, rsp_chan}), 64'd0);
    check("R10 miss latency", 64'(lat), 64'(ENTRIES + 1));
    consume();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule